// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block converts a two-channel serial audio stream into parallel sample words. The stream arrives as a bit clock, a word clock that alternates between the left and the right channel once per sample period, and a data line. The block works in a faster system clock domain, so all three lines are synchronized first, and the rising edges of the bit clock are found there. On each rising edge of the bit clock the block counts bit positions from the last change of the word clock. It then picks out each channel's word according to the selected framing.

A 3-bit format code selects the framing and the word length. The framing can be right-justified, left-justified or I2S, with words of 16, 20 or 24 bits. A polarity input sets which word-clock level means the left channel in the two justified framings. Each word is sign-extended to 24 bits. Both words of a stereo pair are presented together, with a one-cycle strobe when the right word completes. Two format codes are reserved. While either is applied, the outputs freeze and an error flag is raised.

Top module: `saud_rx`

## Requirements
- R1: Data is sampled on the rising edge of the bit clock, MSB first, and each captured word is presented as two's complement sign-extended to 24 bits. The bit clock may carry 16, 24 or 32 bits per word-clock half.
- R2: Format codes 000, 001 and 010 select right-justified framing with N = 16, 20 and 24. The word is the last N bits received before the word-clock transition that ends the half.
- R3: Format code 011 selects left-justified framing with N = 24. The word is the first N bits of the half, starting with the bit sampled at the first bit-clock rise after the transition.
- R4: Format codes 100 and 101 select I2S framing with N = 16 and 24. The word is the N bits that begin one bit after the first bit of the half, so the half must hold at least N+1 bits. The left channel is the word-clock-low half, and the polarity input has no effect.
- R5: In the justified framings, lr_pol_i = 0 makes the word-clock-high half the left channel, and lr_pol_i = 1 makes the low half the left channel.
- R6: pair_vld_o is high for exactly one system clock, in the cycle after the right word of a pair is captured. At that point left_o holds the pair's left word and right_o its right word. right_o changes only together with pair_vld_o, and left_o never changes in a strobe cycle.
- R7: Format codes 110 and 111 are reserved. While one is applied, fmt_err_o is high from the next cycle on, no strobe is produced and left_o and right_o hold their values. fmt_err_o returns low in the cycle after a valid code is applied.
- R8: After reset, left_o and right_o are zero and pair_vld_o and fmt_err_o are low. The first bit-clock rise after reset only records the word-clock level. Bits seen before the first word-clock transition never form an output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bck_i | input | 1 | Serial bit clock (asynchronous) |
| lrck_i | input | 1 | Word clock, one period per stereo sample |
| sdata_i | input | 1 | Serial audio data |
| fmt_i | input | 3 | Format code: framing and word length |
| lr_pol_i | input | 1 | Word-clock level that marks left in the justified framings |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| pair_vld_o | output | 1 | One-cycle strobe when a stereo pair completes |
| fmt_err_o | output | 1 | Reserved format code applied |

## Verification
In right-justified framing, two things happen on the same bit-clock rise: the word of the half that just ended is captured, and the first bit of the new half enters the shifter and restarts the bit counter. The bench fills every slot outside the word with random bits, so any mix-up between the closing word and the opening bit shows up as a miscompare in the scoreboard. Left-justified and I2S bursts at several bits per half then check the other end of the counter, where a capture must land exactly on bit N-1 or bit N. The reserved-code pass checks that a word completing in a cycle where the code is reserved produces no strobe and leaves both outputs unchanged.

// File: rtl/saud_pkg.sv
package saud_pkg;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned CNT_W    = 6;

  typedef enum logic [1:0] {FRM_RJ, FRM_LJ, FRM_I2S, FRM_BAD} frame_e;

  typedef struct packed {
    frame_e     frm;
    logic [4:0] wlen;
  } fmt_t;

  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    unique case (code)
      3'b000:  f = '{frm: FRM_RJ,  wlen: 5'd16};
      3'b001:  f = '{frm: FRM_RJ,  wlen: 5'd20};
      3'b010:  f = '{frm: FRM_RJ,  wlen: 5'd24};
      3'b011:  f = '{frm: FRM_LJ,  wlen: 5'd24};
      3'b100:  f = '{frm: FRM_I2S, wlen: 5'd16};
      3'b101:  f = '{frm: FRM_I2S, wlen: 5'd24};
      default: f = '{frm: FRM_BAD, wlen: 5'd16};
    endcase
    return f;
  endfunction
endpackage

// File: rtl/saud_sync.sv
module saud_sync #(
  parameter int NSIG   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSIG-1:0] async_i,
  output logic [NSIG-1:0] sync_o
);
  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/saud_deser.sv
module saud_deser
  import saud_pkg::*;
#(
  parameter int DW = SAMPLE_W,
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_stb_i,
  input  logic          sd_i,
  input  logic          lr_i,
  input  fmt_t          fmt_i,
  input  logic          pol_i,
  output logic          cap_o,
  output logic          cap_right_o,
  output logic [DW-1:0] word_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          started_q, seen_q, lr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;

  logic          lr_edge, seen_nx, left_lvl, hit;
  logic [CW-1:0] k, n_cw;
  logic [DW-1:0] raw;
  logic [4:0]    shamt;
  logic signed [DW-1:0] aligned;

  assign lr_edge  = started_q && (lr_i != lr_q);
  assign k        = lr_edge ? '0 : ((cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1);
  assign seen_nx  = seen_q | lr_edge;
  assign left_lvl = (fmt_i.frm == FRM_I2S) ? 1'b0 : ~pol_i;
  assign n_cw     = CW'(fmt_i.wlen);

  // right-justified closes the previous half; other framings pick within the current one
  always_comb begin
    hit         = 1'b0;
    cap_right_o = (lr_i != left_lvl);
    unique case (fmt_i.frm)
      FRM_RJ: begin
        hit         = lr_edge && seen_q;
        cap_right_o = (lr_q != left_lvl);
      end
      FRM_LJ:  hit = seen_nx && (k == n_cw - 1'b1);
      FRM_I2S: hit = seen_nx && (k == n_cw);
      default: hit = 1'b0;
    endcase
  end

  assign cap_o   = bit_stb_i && hit;
  assign raw     = (fmt_i.frm == FRM_RJ) ? sh_q : {sh_q[DW-2:0], sd_i};
  assign shamt   = 5'(DW) - fmt_i.wlen;
  assign aligned = $signed(raw << shamt);
  assign word_o  = aligned >>> shamt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      seen_q    <= 1'b0;
      lr_q      <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
    end else if (bit_stb_i) begin
      started_q <= 1'b1;
      lr_q      <= lr_i;
      seen_q    <= seen_nx;
      cnt_q     <= k;
      sh_q      <= {sh_q[DW-2:0], sd_i};
    end
  end
endmodule

// File: rtl/saud_rx.sv
module saud_rx
  import saud_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bck_i,
  input  logic                lrck_i,
  input  logic                sdata_i,
  input  logic [2:0]          fmt_i,
  input  logic                lr_pol_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                pair_vld_o,
  output logic                fmt_err_o
);
  logic [2:0]          s;
  logic                bck_q, bit_stb, cap, cap_right;
  logic [SAMPLE_W-1:0] word;
  fmt_t                fmt;

  saud_sync #(.NSIG(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({bck_i, lrck_i, sdata_i}),
    .sync_o  (s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bck_q <= 1'b0;
    else         bck_q <= s[2];
  end
  assign bit_stb = s[2] & ~bck_q;
  assign fmt     = decode_fmt(fmt_i);

  saud_deser #(.DW(SAMPLE_W), .CW(CNT_W)) u_deser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_stb_i   (bit_stb),
    .sd_i        (s[0]),
    .lr_i        (s[1]),
    .fmt_i       (fmt),
    .pol_i       (lr_pol_i),
    .cap_o       (cap),
    .cap_right_o (cap_right),
    .word_o      (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o     <= '0;
      right_o    <= '0;
      pair_vld_o <= 1'b0;
      fmt_err_o  <= 1'b0;
    end else begin
      fmt_err_o  <= (fmt.frm == FRM_BAD);
      pair_vld_o <= cap && cap_right;
      if (cap && cap_right)  right_o <= word;
      if (cap && !cap_right) left_o  <= word;
    end
  end

  p_bit_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb |=> !bit_stb);
  p_strobe_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_vld_o |=> !pair_vld_o);
  p_right_with_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(right_o) |-> pair_vld_o);
  p_left_off_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(left_o) |-> !pair_vld_o);
  p_err_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i[2:1] == 2'b11) |=> fmt_err_o);
  p_err_no_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i[2:1] == 2'b11) |=> !pair_vld_o);
  p_err_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i[2:1] == 2'b11) |=> ($stable(left_o) && $stable(right_o)));
endmodule

// File: tb/sim_saud_rx.sv
module sim_saud_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bck = 1'b0, lrck = 1'b0, sdata = 1'b0, pol = 1'b0;
  logic [2:0]  fmt = 3'b000;
  logic [23:0] left_o, right_o;
  logic        pair_vld_o, fmt_err_o;

  int vectors = 0;
  int fails   = 0;
  logic [47:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  saud_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .bck_i(bck), .lrck_i(lrck), .sdata_i(sdata),
    .fmt_i(fmt), .lr_pol_i(pol), .left_o(left_o), .right_o(right_o),
    .pair_vld_o(pair_vld_o), .fmt_err_o(fmt_err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pair_vld_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6/R7/R8 unexpected strobe", {left_o, right_o}, 48'h0);
      end else begin
        logic [47:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({left_o, right_o} == e, t, {left_o, right_o}, e);
      end
    end
  end

  function automatic logic [23:0] sext(input logic [23:0] w, input int n);
    logic [23:0] m;
    m = (24'h1 << n) - 24'h1;
    return w[n-1] ? ((w & m) | ~m) : (w & m);
  endfunction

  // frm: 0 right-justified, 1 left-justified, 2 I2S
  function automatic logic pick_bit(input logic [23:0] w, input int n, input int h,
                                    input int frm, input int i);
    int j;
    j = (frm == 0) ? i - (h - n) : ((frm == 1) ? i : i - 1);
    if (j >= 0 && j < n) return w[n-1-j];
    return 1'($urandom);
  endfunction

  task automatic send_bit(input logic b, input logic lr);
    @(negedge clk);
    bck = 1'b0; sdata = b; lrck = lr;
    repeat (3) @(negedge clk);
    bck = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_half(input logic [23:0] w, input int n, input int h,
                           input int frm, input logic lr);
    for (int i = 0; i < h; i++) send_bit(pick_bit(w, n, h, frm, i), lr);
  endtask

  task automatic do_reset(input logic [2:0] code, input logic p);
    @(negedge clk);
    rst_n = 1'b0; bck = 1'b0; fmt = code; pol = p;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic burst(input logic [2:0] code, input logic p, input int h,
                       input int nfr, input string tag);
    int n, frm;
    logic lvl_l;
    logic [23:0] l, r;
    do_reset(code, p);
    case (code)
      3'b000: begin n = 16; frm = 0; end
      3'b001: begin n = 20; frm = 0; end
      3'b010: begin n = 24; frm = 0; end
      3'b011: begin n = 24; frm = 1; end
      3'b100: begin n = 16; frm = 2; end
      default: begin n = 24; frm = 2; end
    endcase
    lvl_l = (frm == 2) ? 1'b0 : ~p;
    // lead-in bits are discarded (R8)
    send_bit(1'b1, ~lvl_l);
    send_bit(1'b0, ~lvl_l);
    for (int f = 0; f < nfr; f++) begin
      l = 24'($urandom);
      r = 24'($urandom);
      exp_q.push_back({sext(l, n), sext(r, n)});
      tag_q.push_back(tag);
      send_half(l, n, h, frm, lvl_l);
      send_half(r, n, h, frm, ~lvl_l);
    end
    if (frm == 0) send_bit(1'($urandom), lvl_l);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " R6 missing strobe"}, 48'(exp_q.size()), 48'h0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [23:0] hl, hr;
    do_reset(3'b000, 1'b0);
    chk({left_o, right_o} == 48'h0, "R8 reset data", {left_o, right_o}, 48'h0);
    chk({pair_vld_o, fmt_err_o} == 2'b00, "R8 reset flags", 48'({pair_vld_o, fmt_err_o}), 48'h0);

    burst(3'b000, 1'b0, 16, 4, "R2 R1 rj16 32fs");
    burst(3'b001, 1'b1, 24, 4, "R2 R5 rj20 48fs pol1");
    burst(3'b010, 1'b0, 32, 4, "R2 rj24 64fs");
    burst(3'b000, 1'b1, 32, 3, "R2 R5 rj16 64fs pol1");
    burst(3'b011, 1'b1, 32, 4, "R3 R5 lj24 64fs pol1");
    burst(3'b011, 1'b0, 24, 4, "R3 lj24 48fs");
    burst(3'b100, 1'b0, 24, 4, "R4 i2s16 48fs");
    burst(3'b101, 1'b1, 32, 4, "R4 i2s24 64fs pol ignored");

    // reserved codes: flag, no strobe, outputs hold (R7)
    burst(3'b010, 1'b0, 32, 2, "R7 pre rj24");
    hl = left_o; hr = right_o;
    for (int c = 6; c < 8; c++) begin
      @(negedge clk);
      fmt = 3'(c);
      repeat (2) @(negedge clk);
      chk(fmt_err_o == 1'b1, "R7 err flag set", 48'(fmt_err_o), 48'h1);
      send_bit(1'b1, 1'b0);
      for (int f = 0; f < 2; f++) begin
        send_half(24'($urandom), 16, 16, 0, 1'b1);
        send_half(24'($urandom), 16, 16, 0, 1'b0);
      end
      send_bit(1'b0, 1'b1);
      repeat (5) @(negedge clk);
      chk({left_o, right_o} == {hl, hr}, "R7 outputs hold", {left_o, right_o}, {hl, hr});
    end
    @(negedge clk);
    fmt = 3'b000;
    repeat (2) @(negedge clk);
    chk(fmt_err_o == 1'b0, "R7 err flag clear", 48'(fmt_err_o), 48'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule